// File: doc/BRIEF.md
# Dual-Mode Parallel Printer Port

This block is the register side of a PC-style parallel printer port. A host reaches four byte-wide locations through a two-bit select: the data location, the printer status location, the control location, and a test location. The block keeps the byte written to the data location in an output latch and shows it on the eight data pins. It drives an output enable for those pins, reads back either the latch or the live pins, and turns the printer acknowledge line into an interrupt.

A configuration input selects one of two modes. In compatible mode the data direction comes from a strap pin captured during reset, and the interrupt simply tracks the acknowledge line. In extended mode a control bit sets the direction, so the port can be turned around under software control. The acknowledge interrupt is then captured on the rising edge of the line, kept in a flag that the status location reports, and cleared by reading that location. All outputs are registers. A write or read is a one-cycle strobe.

Top module: `prn_port`

## Requirements
- R1: While `rst` is high at a clock edge, the output latch, the control register, the interrupt flag, `bus_rdata`, `irq` and `pd_oe` are cleared to 0 at that edge.
- R2: `bus_addr` 0 selects data, 1 selects status, 2 selects control, and 3 selects the test location. A read of location 3 returns all ones. A write to location 3 changes no state. A write to location 1 changes no state.
- R3: `cfg_ext` = 0 selects compatible mode and `cfg_ext` = 1 selects extended mode. Switching the mode changes the direction and the interrupt source from the next edge on.
- R4: `dir_strap` is captured on every edge where `rst` is high. In compatible mode a captured 0 means output direction and 1 means input direction. Changes on `dir_strap` outside reset have no effect.
- R5: At each edge with `rst` low, `pd_oe` becomes 1 exactly when the port is in output direction according to the state before that edge.
- R6: A write to location 0 always loads the output latch, in both modes and both directions. `pd_out` always shows the latch. A read of location 0 returns the latch in output direction and the `pd_in` value present at the read edge in input direction.
- R7: In extended mode, control bit 5 sets the direction: 0 means output and 1 means input.
- R8: In compatible mode, `irq` at each edge becomes control bit 4 AND the `ack` level sampled at that edge.
- R9: In extended mode, a 0-to-1 change of `ack` between two edges sets the interrupt flag. A read of location 1 clears the flag, but a rising edge in the same cycle wins. `irq` at each edge becomes control bit 4 AND the flag value from before the edge.
- R10: A read of location 1 returns `stat_in[4:0]` in bits 7:3, ones in bits 1:0, and in bit 2 the flag from before the read (extended mode) or 1 (compatible mode).
- R11: A write to location 2 stores `bus_wdata[5:0]`. A read of location 2 returns ones in bits 7:6 above the stored six bits. `ctl_out` shows control bits 3:0.
- R12: `bus_rdata` is loaded only at an edge where `bus_rd` is high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ext | input | 1 | Mode select: 0 compatible, 1 extended |
| dir_strap | input | 1 | Direction strap, captured during reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pd_in | input | 8 | Data pin input values |
| pd_out | output | 8 | Data pin output values (output latch) |
| pd_oe | output | 1 | Data pin output enable |
| ack | input | 1 | Printer acknowledge line |
| stat_in | input | 5 | Printer status lines shown in status bits 7:3 |
| ctl_out | output | 4 | Control bits 3:0 to the printer |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is an acknowledge rising edge that lands in the same cycle as a status read in extended mode. In that cycle the read must return the old flag while the flag ends up set. The bench raises `ack` on exactly the cycle the read strobe is held. It then reads again to show that the flag survived, and reads a third time to show that it clears. A second awkward case is the input direction in compatible mode, which only a fresh reset with the strap high can reach. The bench resets the block a second time for it and then toggles the strap to show that the change has no effect.

// File: rtl/prn_port_pkg.sv
package prn_port_pkg;
  localparam logic [1:0] SEL_DATA = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;
  localparam logic [1:0] SEL_TEST = 2'd3;
  localparam int CTL_W       = 6;
  localparam int CTL_DIR_BIT = 5;
  localparam int CTL_IEN_BIT = 4;
  localparam int CTL_OUT_W   = 4;
  localparam int STAT_PIN_W  = 5;
endpackage

// File: rtl/prn_regs.sv
module prn_regs
  import prn_port_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dir_strap,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] latch_q,
  output logic [CTL_W-1:0]  ctl_q,
  output logic              strap_q
);
  logic wr_data, wr_ctrl;
  assign wr_data = bus_wr && (bus_addr == SEL_DATA);
  assign wr_ctrl = bus_wr && (bus_addr == SEL_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      ctl_q   <= '0;
      strap_q <= dir_strap;
    end else begin
      if (wr_data) latch_q <= bus_wdata;
      if (wr_ctrl) ctl_q   <= bus_wdata[CTL_W-1:0];
    end
  end

  assert_test_wr_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == SEL_TEST) |=> ($stable(latch_q) && $stable(ctl_q)));
  assert_strap_hold_R4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(strap_q));
endmodule

// File: rtl/prn_irq.sv
module prn_irq (
  input  logic clk,
  input  logic rst,
  input  logic ext,
  input  logic ack,
  input  logic ien,
  input  logic stat_rd,
  output logic flag_q,
  output logic irq_q
);
  logic ack_q, ack_rise;
  assign ack_rise = ext && ack && !ack_q;

  always_ff @(posedge clk) ack_q <= ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= ien && (ext ? flag_q : ack);
      if (ack_rise)     flag_q <= 1'b1;
      else if (stat_rd) flag_q <= 1'b0;
    end
  end

  assert_flag_set_R9: assert property (@(posedge clk) disable iff (rst)
    (ext && ack && !ack_q) |=> flag_q);
  assert_flag_clr_R9: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !(ext && ack && !ack_q)) |=> !flag_q);
  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (rst)
    !ien |=> !irq_q);
endmodule

// File: rtl/prn_rdmux.sv
module prn_rdmux
  import prn_port_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ext,
  input  logic                  bus_rd,
  input  logic [1:0]            bus_addr,
  input  logic [DATA_W-1:0]     latch,
  input  logic [CTL_W-1:0]      ctl,
  input  logic                  strap,
  input  logic                  flag,
  input  logic [STAT_PIN_W-1:0] stat_pins,
  input  logic [DATA_W-1:0]     pd_in,
  output logic [DATA_W-1:0]     rdata_q,
  output logic                  oe_q
);
  localparam int STAT_PAD = DATA_W - STAT_PIN_W - 1;
  localparam int CTL_PAD  = DATA_W - CTL_W;

  logic              out_dir;
  logic [DATA_W-1:0] rd_val;

  assign out_dir = ext ? !ctl[CTL_DIR_BIT] : !strap;

  always_comb begin
    case (bus_addr)
      SEL_DATA: rd_val = out_dir ? latch : pd_in;
      SEL_STAT: rd_val = {stat_pins, (ext ? flag : 1'b1), {STAT_PAD{1'b1}}};
      SEL_CTRL: rd_val = {{CTL_PAD{1'b1}}, ctl};
      default:  rd_val = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      oe_q    <= 1'b0;
    end else begin
      oe_q <= out_dir;
      if (bus_rd) rdata_q <= rd_val;
    end
  end

  assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(rdata_q));
endmodule

// File: rtl/prn_port.sv
module prn_port
  import prn_port_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_ext,
  input  logic                  dir_strap,
  input  logic [1:0]            bus_addr,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic [DATA_W-1:0]     pd_in,
  output logic [DATA_W-1:0]     pd_out,
  output logic                  pd_oe,
  input  logic                  ack,
  input  logic [STAT_PIN_W-1:0] stat_in,
  output logic [CTL_OUT_W-1:0]  ctl_out,
  output logic                  irq
);
  logic [DATA_W-1:0] latch;
  logic [CTL_W-1:0]  ctl;
  logic              strap, flag, stat_rd;

  assign stat_rd = bus_rd && (bus_addr == SEL_STAT);

  prn_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .dir_strap(dir_strap), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .latch_q(latch), .ctl_q(ctl),
    .strap_q(strap)
  );

  prn_irq u_irq (
    .clk(clk), .rst(rst), .ext(cfg_ext), .ack(ack), .ien(ctl[CTL_IEN_BIT]),
    .stat_rd(stat_rd), .flag_q(flag), .irq_q(irq)
  );

  prn_rdmux #(.DATA_W(DATA_W)) u_rdmux (
    .clk(clk), .rst(rst), .ext(cfg_ext), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .latch(latch), .ctl(ctl), .strap(strap), .flag(flag), .stat_pins(stat_in),
    .pd_in(pd_in), .rdata_q(bus_rdata), .oe_q(pd_oe)
  );

  assign pd_out  = latch;
  assign ctl_out = ctl[CTL_OUT_W-1:0];

  assert_oe_dir_R5: assert property (@(posedge clk) disable iff (rst)
    (cfg_ext && ctl[CTL_DIR_BIT]) |=> !pd_oe);
endmodule

// File: tb/prn_port_test.sv
module prn_port_test;
  logic       clk = 0, rst = 1, cfg_ext = 0, dir_strap = 0;
  logic [1:0] bus_addr = 0;
  logic       bus_wr = 0, bus_rd = 0, ack = 0;
  logic [7:0] bus_wdata = 0, pd_in = 8'h3C;
  logic [4:0] stat_in = 5'b10110;
  logic [7:0] bus_rdata, pd_out;
  logic       pd_oe, irq;
  logic [3:0] ctl_out;

  int checks = 0, errors = 0;
  bit cmp_on = 0;

  always #2 clk = ~clk;

  prn_port uut (
    .clk(clk), .rst(rst), .cfg_ext(cfg_ext), .dir_strap(dir_strap),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pd_in(pd_in), .pd_out(pd_out), .pd_oe(pd_oe),
    .ack(ack), .stat_in(stat_in), .ctl_out(ctl_out), .irq(irq)
  );

  // reference model
  logic [7:0] m_latch, m_rdata;
  logic [5:0] m_ctl;
  logic       m_strap, m_flag, m_ackq, m_irq, m_oe;

  always @(posedge clk) begin
    bit odir, rise;
    logic [7:0] rv;
    odir = cfg_ext ? !m_ctl[5] : !m_strap;
    rise = cfg_ext && ack && !m_ackq;
    case (bus_addr)
      2'd0: rv = odir ? m_latch : pd_in;
      2'd1: rv = {stat_in, (cfg_ext ? m_flag : 1'b1), 2'b11};
      2'd2: rv = {2'b11, m_ctl};
      default: rv = 8'hFF;
    endcase
    if (rst) begin
      m_latch = 0; m_ctl = 0; m_strap = dir_strap; m_flag = 0;
      m_rdata = 0; m_irq = 0; m_oe = 0;
    end else begin
      m_oe  = odir;
      m_irq = m_ctl[4] && (cfg_ext ? m_flag : ack);
      if (bus_rd) m_rdata = rv;
      if (bus_wr && bus_addr == 2'd0) m_latch = bus_wdata;
      if (bus_wr && bus_addr == 2'd2) m_ctl = bus_wdata[5:0];
      if (rise) m_flag = 1;
      else if (bus_rd && bus_addr == 2'd1) m_flag = 0;
    end
    m_ackq = ack;
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    chk("R6 pd_out", pd_out, m_latch);
    chk("R5 pd_oe", {7'd0, pd_oe}, {7'd0, m_oe});
    chk("R8/R9 irq", {7'd0, irq}, {7'd0, m_irq});
    chk("R12 bus_rdata", bus_rdata, m_rdata);
    chk("R11 ctl_out", {4'd0, ctl_out}, {4'd0, m_ctl[3:0]});
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    cyc(1);
    bus_wr = 0;
  endtask
  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    bus_addr = a; bus_rd = 1;
    @(negedge clk);
    chk(tag, bus_rdata, exp);
    #1 bus_rd = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1;
    cyc(3);
    // R1 reset state
    chk("R1 pd_out", pd_out, 8'h00);
    chk("R1 pd_oe", {7'd0, pd_oe}, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 rdata", bus_rdata, 8'h00);
    chk("R1 ctl_out", {4'd0, ctl_out}, 8'h00);
    cmp_on = 1;
    rst = 0;
    cyc(2);
    chk("R4 compat output oe", {7'd0, pd_oe}, 8'h01);
    // R6 compat output: write and read latch
    wr(2'd0, 8'hA5);
    rd(2'd0, 8'hA5, "R6 compat read latch");
    // R2 test location
    wr(2'd3, 8'h00);
    wr(2'd1, 8'h00);
    rd(2'd3, 8'hFF, "R2 test read");
    rd(2'd0, 8'hA5, "R2 test write ignored");
    rd(2'd2, 8'hC0, "R2 ctrl unchanged");
    // R8 compat interrupt follows ack
    wr(2'd2, 8'h15);
    rd(2'd2, 8'hD5, "R11 ctrl readback");
    ack = 1; cyc(2);
    chk("R8 irq follows ack", {7'd0, irq}, 8'h01);
    ack = 0; cyc(2);
    chk("R8 irq drops", {7'd0, irq}, 8'h00);
    rd(2'd1, 8'hB7, "R10 compat status");
    // R3 / R7 extended mode, output direction
    cfg_ext = 1; cyc(2);
    chk("R7 ext out oe", {7'd0, pd_oe}, 8'h01);
    rd(2'd1, 8'hB3, "R10 ext status no flag");
    ack = 1; cyc(3);
    chk("R9 irq from flag", {7'd0, irq}, 8'h01);
    rd(2'd1, 8'hB7, "R9 flag seen");
    rd(2'd1, 8'hB3, "R9 flag cleared");
    ack = 0; cyc(2);
    // rising edge in same cycle as status read: set wins
    bus_addr = 2'd1; bus_rd = 1; ack = 1;
    @(negedge clk);
    chk("R9 same-cycle read old", bus_rdata, 8'hB3);
    #1 bus_rd = 0;
    rd(2'd1, 8'hB7, "R9 set wins");
    rd(2'd1, 8'hB3, "R9 cleared after");
    ack = 0; cyc(1);
    // R7 extended input direction
    wr(2'd2, 8'h25);
    cyc(1);
    chk("R7 ext in oe off", {7'd0, pd_oe}, 8'h00);
    wr(2'd0, 8'h5A);
    chk("R6 latch loads in input dir", pd_out, 8'h5A);
    pd_in = 8'h96;
    rd(2'd0, 8'h96, "R6 ext read pins");
    wr(2'd2, 8'hC5);
    rd(2'd0, 8'h5A, "R6 ext read latch");
    rd(2'd2, 8'hC5, "R11 bits 7:6 read one");
    // ien off: flag sets but no irq
    wr(2'd2, 8'h03);
    ack = 1; cyc(3);
    chk("R9 irq gated", {7'd0, irq}, 8'h00);
    rd(2'd1, 8'hB7, "R9 flag without enable");
    ack = 0;
    // R3 back to compat: direction from strap again
    cfg_ext = 0; cyc(2);
    chk("R3 compat oe", {7'd0, pd_oe}, 8'h01);
    // R4 strap input direction via new reset
    dir_strap = 1; rst = 1; cyc(2);
    chk("R1 oe in reset", {7'd0, pd_oe}, 8'h00);
    rst = 0; dir_strap = 0; cyc(3);
    chk("R4 strap input oe", {7'd0, pd_oe}, 8'h00);
    wr(2'd0, 8'h11);
    pd_in = 8'hE7;
    rd(2'd0, 8'hE7, "R4 compat input read pins");
    chk("R6 pd_out latch", pd_out, 8'h11);
    cyc(3);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule